// File: doc/BRIEF.md
# Rendezvous Channel Writer and Reader

This block carries one signed data word from a writer process to a reader process over an unbuffered channel. Each process is switched on by a one-cycle activation token and hands back a one-cycle done token when its part of the exchange is complete. A controller can chain these tokens to sequence larger process networks. No data is stored in the channel. A transfer takes place only while both ends are active, so the two processes meet at the channel and neither can run ahead of the other.

The writer shows its stored word together with a valid bit for as long as it is active. The reader answers with a combinational acknowledge in the first cycle in which it is active and sees valid data. It captures the word on that edge. One cycle later the writer sees the registered acknowledge and returns its own token. The reader keeps the last word it received on its output until the next transfer. The channel link between the two state machines contains only wiring, so a buffered link can replace it without changing either end.

Top module: `csp_rendezvous`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset, wr_done_o, rd_done_o and chan_valid_o are 0, and chan_data_o and rd_data_o are 0.
- R2: Once the writer has taken a token, chan_valid_o is 1 from the next cycle on. In each cycle of that wait, chan_data_o equals the wr_data_i value sampled at the previous rising edge.
- R3: Whenever chan_valid_o is 0, chan_data_o is 0.
- R4: rd_done_o is 1 in exactly the cycles in which the reader holds a token and chan_valid_o is 1. rd_data_o takes chan_data_o at the end of that cycle.
- R5: wr_done_o is 1 for exactly one cycle, the cycle right after rd_done_o was 1. In that cycle chan_valid_o is 0. After it, the writer is idle.
- R6: While the writer is active and the reader holds no token, chan_valid_o stays 1, wr_done_o stays 0, and rd_data_o does not change, for any length of wait.
- R7: A reader token that arrives before the writer is kept. While chan_valid_o is 0, rd_done_o stays 0 and rd_data_o does not change. The transfer completes as soon as the writer becomes active.
- R8: rd_data_o changes only at the edge that ends a cycle with rd_done_o at 1. The full signed range, including the most negative value, is transferred unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_token_i | input | 1 | Activation token for the writer |
| wr_data_i | input | DATA_W | Signed word to send |
| wr_done_o | output | 1 | Writer returns its token |
| rd_token_i | input | 1 | Activation token for the reader |
| rd_done_o | output | 1 | Reader returns its token (acknowledge) |
| rd_data_o | output | DATA_W | Last word received, signed |
| chan_valid_o | output | 1 | Channel carries valid data |
| chan_data_o | output | DATA_W | Channel data, zero when invalid |

## Verification
A writer that loses its acknowledge flag would leave chan_valid_o high forever and never raise wr_done_o. A writer whose flag sticks would raise wr_done_o one cycle early or more than once. Either fault shows within two cycles of rd_done_o. A reader whose token is not sticky drops a reader-first transfer, and rd_done_o then never appears when the writer starts. A capture on the wrong edge shows at rd_data_o one cycle after the acknowledge. All 256 signed words are sent through the channel. Stalls of one to five cycles on each side are tested, and the writer's data changes while it waits.

// File: rtl/csp_rdv_pkg.sv
package csp_rdv_pkg;
  parameter int unsigned DATA_W_DEF = 8;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_SEND = 2'd1,
    WR_ACK  = 2'd2
  } wr_phase_e;
endpackage

// File: rtl/csp_chan_writer.sv
module csp_chan_writer
  import csp_rdv_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     token_i,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic                     success_i,
  output logic                     done_o,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] data_o
);
  logic                     tok_q, tok_d;
  logic                     succ_q, succ_d;
  logic signed [DATA_W-1:0] val_q;
  wr_phase_e                phase;

  always_comb begin
    if (!tok_q)      phase = WR_IDLE;
    else if (succ_q) phase = WR_ACK;
    else             phase = WR_SEND;
  end

  always_comb begin
    tok_d   = token_i;
    succ_d  = success_i;
    done_o  = 1'b0;
    valid_o = 1'b0;
    data_o  = '0;
    unique case (phase)
      WR_SEND: begin
        tok_d   = 1'b1;
        valid_o = 1'b1;
        data_o  = val_q;
      end
      WR_ACK: begin
        tok_d  = 1'b0;
        succ_d = 1'b0;
        done_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q  <= 1'b0;
      succ_q <= 1'b0;
      val_q  <= '0;
    end else begin
      tok_q  <= tok_d;
      succ_q <= succ_d;
      val_q  <= data_i;
    end
  end

  p_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !success_i) |=> valid_o);
  p_done_after_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(success_i));
  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/csp_chan_link.sv
module csp_chan_link #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                     wr_valid_i,
  input  logic signed [DATA_W-1:0] wr_data_i,
  output logic                     wr_success_o,
  output logic                     rd_valid_o,
  output logic signed [DATA_W-1:0] rd_data_o,
  input  logic                     rd_success_i
);
  // Unbuffered: straight wiring, swap point for a buffered link
  assign rd_valid_o   = wr_valid_i;
  assign rd_data_o    = wr_data_i;
  assign wr_success_o = rd_success_i;
endmodule

// File: rtl/csp_chan_reader.sv
module csp_chan_reader #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     token_i,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic                     success_o,
  output logic                     done_o,
  output logic signed [DATA_W-1:0] data_o
);
  logic                     tok_q, tok_d;
  logic signed [DATA_W-1:0] val_q, val_d;
  logic                     take;

  assign take = tok_q && valid_i;

  always_comb begin
    val_d = val_q;
    tok_d = tok_q || token_i;  // token held until the writer shows up
    if (take) begin
      val_d = data_i;
      tok_d = 1'b0;
    end
  end

  assign success_o = take;
  assign done_o    = take;
  assign data_o    = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q <= 1'b0;
      val_q <= '0;
    end else begin
      tok_q <= tok_d;
      val_q <= val_d;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(data_o));
  p_zero_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (data_i == '0));
endmodule

// File: rtl/csp_rendezvous.sv
module csp_rendezvous
  import csp_rdv_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_token_i,
  input  logic signed [DATA_W-1:0] wr_data_i,
  output logic                     wr_done_o,
  input  logic                     rd_token_i,
  output logic                     rd_done_o,
  output logic signed [DATA_W-1:0] rd_data_o,
  output logic                     chan_valid_o,
  output logic signed [DATA_W-1:0] chan_data_o
);
  logic                     w_valid, r_valid, w_succ, r_succ;
  logic signed [DATA_W-1:0] w_data, r_data;

  csp_chan_writer #(.DATA_W(DATA_W)) i_writer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .token_i   (wr_token_i),
    .data_i    (wr_data_i),
    .success_i (w_succ),
    .done_o    (wr_done_o),
    .valid_o   (w_valid),
    .data_o    (w_data)
  );

  csp_chan_link #(.DATA_W(DATA_W)) i_link (
    .wr_valid_i   (w_valid),
    .wr_data_i    (w_data),
    .wr_success_o (w_succ),
    .rd_valid_o   (r_valid),
    .rd_data_o    (r_data),
    .rd_success_i (r_succ)
  );

  csp_chan_reader #(.DATA_W(DATA_W)) i_reader (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .token_i   (rd_token_i),
    .valid_i   (r_valid),
    .data_i    (r_data),
    .success_o (r_succ),
    .done_o    (rd_done_o),
    .data_o    (rd_data_o)
  );

  assign chan_valid_o = w_valid;
  assign chan_data_o  = w_data;

  p_ack_needs_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |-> chan_valid_o);
  p_done_invalid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> !chan_valid_o);
endmodule

// File: tb/test_csp_rendezvous.sv
module test_csp_rendezvous;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_token_i = 1'b0, rd_token_i = 1'b0;
  logic signed [DW-1:0] wr_data_i = '0;
  logic wr_done_o, rd_done_o, chan_valid_o;
  logic signed [DW-1:0] rd_data_o, chan_data_o;

  int n_checks = 0;
  int n_errors = 0;
  int last_rd = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  csp_rendezvous #(.DATA_W(DW)) i_csp_rendezvous (
    .clk_i, .rst_ni, .wr_token_i, .wr_data_i, .wr_done_o,
    .rd_token_i, .rd_done_o, .rd_data_o, .chan_valid_o, .chan_data_o
  );

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic nedge();
    @(negedge clk_i);
  endtask

  // R3 on every sampled cycle
  task automatic chk_zero();
    if (!chan_valid_o) chk("R3 zero when invalid", int'(chan_data_o), 0);
  endtask

  task automatic both_at_once(int v);
    wr_data_i = DW'(v); wr_token_i = 1'b1; rd_token_i = 1'b1;
    nedge();
    wr_token_i = 1'b0; rd_token_i = 1'b0;
    chk("R2 valid", int'(chan_valid_o), 1);
    chk("R2 data", int'(chan_data_o), v);
    chk("R4 rd_done", int'(rd_done_o), 1);
    chk("R5 no early wr_done", int'(wr_done_o), 0);
    nedge();
    chk("R5 wr_done", int'(wr_done_o), 1);
    chk("R5 invalid on done", int'(chan_valid_o), 0);
    chk("R4 rd_done single", int'(rd_done_o), 0);
    chk("R8 captured", int'(rd_data_o), v);
    chk_zero();
    nedge();
    chk("R5 wr_done single", int'(wr_done_o), 0);
    chk("R5 idle", int'(chan_valid_o), 0);
    last_rd = v;
  endtask

  task automatic writer_first(int k, int base);
    int cur = base;
    wr_data_i = DW'(cur); wr_token_i = 1'b1;
    nedge();
    wr_token_i = 1'b0;
    for (int i = 0; i < k; i++) begin
      chk("R6 valid holds", int'(chan_valid_o), 1);
      chk("R2 data follows input", int'(chan_data_o), cur);
      chk("R6 no wr_done", int'(wr_done_o), 0);
      chk("R6 no rd_done", int'(rd_done_o), 0);
      chk("R6 rd_data held", int'(rd_data_o), last_rd);
      cur = int'($signed(DW'(cur + 37)));
      wr_data_i = DW'(cur);
      nedge();
    end
    rd_token_i = 1'b1;
    chk("R2 data follows input", int'(chan_data_o), cur);
    nedge();
    rd_token_i = 1'b0;
    chk("R4 rd_done late reader", int'(rd_done_o), 1);
    chk("R2 latest data", int'(chan_data_o), cur);
    nedge();
    chk("R5 wr_done late reader", int'(wr_done_o), 1);
    chk("R8 captured latest", int'(rd_data_o), cur);
    nedge();
    chk("R5 wr_done single", int'(wr_done_o), 0);
    last_rd = cur;
  endtask

  task automatic reader_first(int k, int v);
    rd_token_i = 1'b1;
    nedge();
    rd_token_i = 1'b0;
    for (int i = 0; i < k; i++) begin
      chk("R7 no rd_done", int'(rd_done_o), 0);
      chk("R7 rd_data held", int'(rd_data_o), last_rd);
      chk("R7 invalid", int'(chan_valid_o), 0);
      chk_zero();
      nedge();
    end
    wr_data_i = DW'(v); wr_token_i = 1'b1;
    nedge();
    wr_token_i = 1'b0;
    chk("R7 rd_done on writer arrival", int'(rd_done_o), 1);
    chk("R2 data", int'(chan_data_o), v);
    nedge();
    chk("R5 wr_done", int'(wr_done_o), 1);
    chk("R8 captured", int'(rd_data_o), v);
    nedge();
    last_rd = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    nedge();
    chk("R1 wr_done reset", int'(wr_done_o), 0);
    chk("R1 rd_done reset", int'(rd_done_o), 0);
    chk("R1 valid reset", int'(chan_valid_o), 0);
    chk("R1 rd_data reset", int'(rd_data_o), 0);
    chk("R1 chan_data reset", int'(chan_data_o), 0);
    nedge();
    rst_ni = 1'b1;
    nedge();
    chk("R1 valid after reset", int'(chan_valid_o), 0);
    chk("R1 rd_done after reset", int'(rd_done_o), 0);
    chk("R1 wr_done after reset", int'(wr_done_o), 0);
    chk_zero();

    // R8 full signed sweep
    for (int v = -128; v < 128; v++) both_at_once(v);
    // idle gap: rd_data_o stays put
    for (int i = 0; i < 3; i++) begin
      nedge();
      chk("R8 hold between transfers", int'(rd_data_o), last_rd);
    end
    for (int k = 1; k <= 5; k++) writer_first(k, 20 * k - 70);
    for (int k = 1; k <= 5; k++) reader_first(k, 100 - 45 * k);
    both_at_once(-128);
    both_at_once(127);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule